// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a 32-bit physical byte address into one of eight active-low chip selects for external devices. Each select has its own configuration word with a region base, a compare mask, an enable bit and a device-width code. Software loads these words through a simple register-write port. Only addresses below 0x2000_0000 are served, and the first megabyte of that window is never decoded.

Each access request carries an address, a transfer size and a read/write flag. One cycle after the request, the block drives a single registered result for exactly one cycle. That result is either one select low together with the external address pins, byte-lane enables and a read or write strobe, or the miss flag. The external address pins take the low address bits. For a 16-bit device, pin 0 is held at zero and the upper pins carry the byte address from bit 1 upward. When no request is presented, every select stays high.

Top module: `cs_addr_decoder`

## Requirements
- R1: After reset, all configuration words are zero and every select is disabled. The cs_n outputs are all high, miss is low, ext_we_n and ext_oe_n are high, ext_be_n is 2'b11 and ext_addr is zero.
- R2: The configuration word for select k is written when cfg_wr_en is high with cfg_wr_sel = k. Its fields are: base in bits 5:0, enable in bit 6, compare mask in bits 11:8 and device width in bits 13:12. A select whose enable bit is 0 is never asserted, so the word 0x0000_0F04 leaves it off and 0x0000_0F44 turns it on.
- R3: An enabled select matches when address bits 29:28 equal base bits 5:4, and when every address bit among 27:24 whose mask bit is 1 equals the corresponding base bit among 3:0.
- R4: Mask 0xF gives a 16 MB region, 0xC a 64 MB region and 0x0 a 256 MB region. Each region is aligned to its own size, so base 4 with mask 0xC covers 0x0400_0000 to 0x07FF_FFFF.
- R5: An address below 0x0010_0000 gives miss and asserts no select, even when a region covers it. The address 0x0010_0000 itself decodes normally.
- R6: An address at or above 0x2000_0000 gives miss and asserts no select.
- R7: When several enabled regions match, only the lowest-numbered select is asserted.
- R8: A request presented in the cycle ending at edge n produces its result in the cycle after edge n, for one cycle only. In that cycle exactly one of miss or a single select is active. A cycle without a request gives all selects high and miss low.
- R9: For width code 00 (8-bit device), ext_addr equals address bits EXT_AW-1:0.
- R10: For any other width code (16-bit device), ext_addr bit 0 is 0 and ext_addr bits EXT_AW-1:1 equal address bits EXT_AW-1:1.
- R11: On a miss, and when no request is presented, ext_addr is zero, both strobes are high and ext_be_n is 2'b11.
- R12: With a select asserted, ext_we_n is low for a write request and ext_oe_n is low for a read request. The other strobe stays high.
- R13: With a select asserted, ext_be_n (active low, bit 0 = lane of even bytes) depends on the device and the transfer size. It is 2'b10 for an 8-bit device. For a 16-bit device with req_size 0 (byte) it selects only the lane given by address bit 0. For a 16-bit device with req_size 1 or 2 it is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 3 | Index of the select whose word is written |
| cfg_wr_data | input | 32 | Configuration word |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Physical byte address |
| req_size | input | 2 | Transfer size: 0 byte, 1 half, 2 word |
| req_write | input | 1 | 1 for write, 0 for read |
| cs_n | output | 8 | Active-low chip selects |
| miss | output | 1 | Request decoded to no select |
| ext_addr | output | 20 | External address pins |
| ext_be_n | output | 2 | Active-low byte-lane enables |
| ext_we_n | output | 1 | Active-low write strobe |
| ext_oe_n | output | 1 | Active-low read strobe |

## Verification
The block's only lasting state is its set of configuration words. A corrupted base, mask, enable or width field shows up on the very next request that touches that region: the wrong select goes low, the miss flag is wrong, or the address and lane pattern is wrong, one cycle after the request. The per-request output registers hold state for only a single cycle. A result that lingers or leaks appears as a select still low, or as miss set, in the idle cycle that follows a request. The bench therefore checks every access and the idle cycle after it.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  localparam int CFG_DW = 32;

  typedef struct packed {
    logic [1:0] dwidth;
    logic [3:0] mask;
    logic       enable;
    logic [5:0] base;
  } cs_cfg_t;

  localparam cs_cfg_t CFG_RESET = '0;

  function automatic cs_cfg_t cfg_from_word(input logic [13:0] w);
    cs_cfg_t c;
    c.base   = w[5:0];
    c.enable = w[6];
    c.mask   = w[11:8];
    c.dwidth = w[13:12];
    return c;
  endfunction

  function automatic logic region_hit(input cs_cfg_t c, input logic [29:24] a);
    logic upper_eq;
    logic lower_eq;
    upper_eq = (a[29:28] == c.base[5:4]);
    lower_eq = (((a[27:24] ^ c.base[3:0]) & c.mask) == 4'h0);
    return c.enable && upper_eq && lower_eq;
  endfunction

  function automatic logic in_window(input logic [31:20] a);
    return (a[31:29] == 3'b000) && (a[28:20] != 9'h000);
  endfunction

  function automatic logic [1:0] lanes_n(input logic a0, input logic [1:0] size,
                                         input logic [1:0] dwidth);
    if (dwidth == 2'b00) return 2'b10;
    if (size == 2'b00)   return a0 ? 2'b01 : 2'b10;
    return 2'b00;
  endfunction

endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [CFG_DW-1:0]       wr_data,
  output cs_cfg_t [NUM_CS-1:0]    cfg_o
);

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[CFG_DW-1:14], wr_data[7]};

  for (genvar k = 0; k < NUM_CS; k++) begin : g_word
    cs_cfg_t word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= CFG_RESET;
      else if (wr_en && (wr_sel == k[SEL_W-1:0]))
        word_q <= cfg_from_word(wr_data[13:0]);
    end
    assign cfg_o[k] = word_q;
  end

endmodule

// File: rtl/cs_region_match.sv
module cs_region_match
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  cs_cfg_t [NUM_CS-1:0] cfg_i,
  input  logic [31:20]         addr_hi,
  output logic [NUM_CS-1:0]    hit_o
);

  logic win_ok;
  assign win_ok = in_window(addr_hi);

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cmp
    assign hit_o[k] = win_ok && region_hit(cfg_i[k], addr_hi[29:24]);
  end

endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int NUM_CS = 8,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic [NUM_CS-1:0] hit_i,
  output logic [NUM_CS-1:0] grant_o,
  output logic [SEL_W-1:0]  idx_o,
  output logic              any_o
);

  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = i[SEL_W-1:0];
        any_o      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cs_addr_decoder.sv
module cs_addr_decoder
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int EXT_AW = 20,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_wr_sel,
  input  logic [31:0]       cfg_wr_data,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  output logic [NUM_CS-1:0] cs_n,
  output logic              miss,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [1:0]        ext_be_n,
  output logic              ext_we_n,
  output logic              ext_oe_n
);

  function automatic logic [EXT_AW-1:0] pin_map(input logic [EXT_AW-1:0] a,
                                                input logic [1:0] dwidth);
    logic [EXT_AW-1:0] p;
    p = a;
    if (dwidth != 2'b00) p[0] = 1'b0;
    return p;
  endfunction

  cs_cfg_t [NUM_CS-1:0] cfg_vec;
  logic [NUM_CS-1:0]    dec_hit_vec;
  logic [NUM_CS-1:0]    dec_grant;
  logic [SEL_W-1:0]     dec_idx;
  logic                 dec_any;
  logic [NUM_CS-1:0]    cfg_en_vec;
  logic [1:0]           win_width;

  cs_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_wr_sel),
    .wr_data (cfg_wr_data),
    .cfg_o   (cfg_vec)
  );

  cs_region_match #(.NUM_CS(NUM_CS)) u_match (
    .cfg_i   (cfg_vec),
    .addr_hi (req_addr[31:20]),
    .hit_o   (dec_hit_vec)
  );

  cs_prio_pick #(.NUM_CS(NUM_CS)) u_pick (
    .hit_i   (dec_hit_vec),
    .grant_o (dec_grant),
    .idx_o   (dec_idx),
    .any_o   (dec_any)
  );

  for (genvar k = 0; k < NUM_CS; k++) begin : g_en
    assign cfg_en_vec[k] = cfg_vec[k].enable;
  end

  assign win_width = cfg_vec[dec_idx].dwidth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n     <= '1;
      miss     <= 1'b0;
      ext_addr <= '0;
      ext_be_n <= 2'b11;
      ext_we_n <= 1'b1;
      ext_oe_n <= 1'b1;
    end else if (req_valid && dec_any) begin
      cs_n     <= ~dec_grant;
      miss     <= 1'b0;
      ext_addr <= pin_map(req_addr[EXT_AW-1:0], win_width);
      ext_be_n <= lanes_n(req_addr[0], req_size, win_width);
      ext_we_n <= ~req_write;
      ext_oe_n <= req_write;
    end else begin
      cs_n     <= '1;
      miss     <= req_valid;
      ext_addr <= '0;
      ext_be_n <= 2'b11;
      ext_we_n <= 1'b1;
      ext_oe_n <= 1'b1;
    end
  end

endmodule

// File: rtl/cs_addr_decoder_chk.sv
module cs_addr_decoder_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [31:20]      req_addr_hi,
  input logic              req_write,
  input logic [NUM_CS-1:0] cs_n,
  input logic              miss,
  input logic              ext_we_n,
  input logic              ext_oe_n,
  input logic [NUM_CS-1:0] cfg_en_vec
);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (&cs_n && !miss && ext_we_n && ext_oe_n));

  assert_decided_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (miss != !(&cs_n)));

  assert_single_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_miss_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (&cs_n && ext_we_n && ext_oe_n));

  assert_low_mb_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr_hi == 12'h000) |=> miss);

  assert_out_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr_hi[31:29] != 3'b000) |=> miss);

  assert_enabled_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cs_n) & ~$past(cfg_en_vec)) == '0);

  assert_read_no_we_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> ext_we_n);

endmodule

bind cs_addr_decoder cs_addr_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr_hi (req_addr[31:20]),
  .req_write   (req_write),
  .cs_n        (cs_n),
  .miss        (miss),
  .ext_we_n    (ext_we_n),
  .ext_oe_n    (ext_oe_n),
  .cfg_en_vec  (cfg_en_vec)
);

// File: tb/cs_addr_decoder_tb.sv
module cs_addr_decoder_tb;

  localparam int NCS = 8;
  localparam int AW  = 20;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_wr_en = 1'b0;
  logic [2:0]     cfg_wr_sel = '0;
  logic [31:0]    cfg_wr_data = '0;
  logic           req_valid = 1'b0;
  logic [31:0]    req_addr = '0;
  logic [1:0]     req_size = '0;
  logic           req_write = 1'b0;
  logic [NCS-1:0] cs_n;
  logic           miss;
  logic [AW-1:0]  ext_addr;
  logic [1:0]     ext_be_n;
  logic           ext_we_n;
  logic           ext_oe_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [5:0] sh_base [NCS];
  logic [3:0] sh_mask [NCS];
  logic       sh_en   [NCS];
  logic [1:0] sh_w    [NCS];

  always #5 clk = ~clk;

  cs_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .cs_n(cs_n), .miss(miss), .ext_addr(ext_addr), .ext_be_n(ext_be_n),
    .ext_we_n(ext_we_n), .ext_oe_n(ext_oe_n)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Reference: a region is a byte range of 16 MB << (trailing clear mask bits).
  function automatic int ref_pick(input logic [31:0] a);
    for (int i = 0; i < NCS; i++) begin
      if (sh_en[i]) begin
        longint span, lo;
        int tz;
        tz = 0;
        while (tz < 4 && sh_mask[i][tz] == 1'b0) tz++;
        span = 64'h100_0000 << tz;
        lo   = (longint'(sh_base[i]) << 24) & ~(span - 1);
        if (longint'(a) >= lo && longint'(a) < lo + span) return i;
      end
    end
    return -1;
  endfunction

  task automatic cfg_write(input int k, input logic [5:0] base, input logic en,
                           input logic [3:0] mask, input logic [1:0] w);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_sel  = k[2:0];
    cfg_wr_data = (32'(w) << 12) | (32'(mask) << 8) | (32'(en) << 6) | 32'(base);
    @(negedge clk);
    cfg_wr_en   = 1'b0;
    sh_base[k] = base; sh_mask[k] = mask; sh_en[k] = en; sh_w[k] = w;
  endtask

  // Presents one request, checks the result one cycle later and the idle cycle after.
  task automatic access(input string tag, input logic [31:0] a, input logic [1:0] sz,
                        input logic wr);
    int sel;
    logic [NCS-1:0] exp_cs;
    logic [AW-1:0]  exp_addr;
    logic [1:0]     exp_be;
    bit in_win;
    in_win = (a >= 32'h0010_0000) && (a < 32'h2000_0000);
    sel = in_win ? ref_pick(a) : -1;
    exp_cs = '1;
    exp_addr = '0;
    exp_be = 2'b11;
    if (sel >= 0) begin
      exp_cs[sel] = 1'b0;
      exp_addr = a[AW-1:0];
      if (sh_w[sel] != 2'b00) exp_addr[0] = 1'b0;
      if (sh_w[sel] == 2'b00)  exp_be = 2'b10;
      else if (sz == 2'b00)    exp_be = a[0] ? 2'b01 : 2'b10;
      else                     exp_be = 2'b00;
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, "cs_n", cs_n, exp_cs);
    check(tag, "miss", miss, (sel < 0));
    check(tag, "ext_addr", ext_addr, exp_addr);
    check(tag, "ext_be_n", ext_be_n, exp_be);
    check(tag, "ext_we_n", ext_we_n, !(sel >= 0 && wr));
    check(tag, "ext_oe_n", ext_oe_n, !(sel >= 0 && !wr));
    @(negedge clk);
    check("R8", "idle cs_n", cs_n, {NCS{1'b1}});
    check("R8", "idle miss", miss, 0);
  endtask

  task automatic t_reset();
    check("R1", "cs_n", cs_n, {NCS{1'b1}});
    check("R1", "miss", miss, 0);
    check("R1", "ext_we_n", ext_we_n, 1);
    check("R1", "ext_oe_n", ext_oe_n, 1);
    check("R1", "ext_be_n", ext_be_n, 2'b11);
    check("R1", "ext_addr", ext_addr, 0);
    access("R1", 32'h0100_0000, 2'd0, 1'b0);
    check("R1", "all selects off -> miss seen", total > 0, 1);
  endtask

  task automatic t_enable_bit();
    cfg_write(1, 6'h04, 1'b0, 4'hF, 2'b00);
    access("R2", 32'h0400_0000, 2'd0, 1'b0);
    cfg_write(1, 6'h04, 1'b1, 4'hF, 2'b00);
    access("R2", 32'h0400_0000, 2'd0, 1'b0);
    access("R3", 32'h04FF_FFFF, 2'd0, 1'b1);
    access("R3", 32'h0500_0000, 2'd0, 1'b0);
  endtask

  task automatic t_region_sizes();
    cfg_write(2, 6'h08, 1'b1, 4'hC, 2'b00);
    access("R4", 32'h0800_0000, 2'd0, 1'b0);
    access("R4", 32'h0BFF_FFFE, 2'd0, 1'b0);
    access("R4", 32'h0C00_0000, 2'd0, 1'b0);
    cfg_write(7, 6'h10, 1'b1, 4'h0, 2'b00);
    access("R4", 32'h1ABC_DEF1, 2'd0, 1'b1);
    access("R3", 32'h1FFF_FFFF, 2'd0, 1'b0);
  endtask

  task automatic t_low_mb();
    cfg_write(0, 6'h00, 1'b1, 4'hF, 2'b00);
    access("R5", 32'h0008_0000, 2'd0, 1'b0);
    access("R5", 32'h0000_0000, 2'd0, 1'b1);
    access("R5", 32'h0010_0000, 2'd0, 1'b0);
  endtask

  task automatic t_window();
    cfg_write(3, 6'h20, 1'b1, 4'hF, 2'b00);
    access("R6", 32'h2000_0000, 2'd0, 1'b0);
    access("R6", 32'hF000_0000, 2'd0, 1'b1);
  endtask

  task automatic t_priority();
    cfg_write(4, 6'h09, 1'b1, 4'hF, 2'b00);
    access("R7", 32'h0912_3456, 2'd0, 1'b0);
    cfg_write(2, 6'h08, 1'b0, 4'hC, 2'b00);
    access("R7", 32'h0912_3456, 2'd0, 1'b0);
    access("R7", 32'h0A00_0000, 2'd0, 1'b0);
  endtask

  task automatic t_width();
    access("R9", 32'h0412_3457, 2'd0, 1'b0);
    cfg_write(1, 6'h04, 1'b1, 4'hF, 2'b01);
    access("R10", 32'h0400_0003, 2'd0, 1'b0);
    access("R10", 32'h04AB_CDE5, 2'd1, 1'b1);
    access("R13", 32'h0400_0002, 2'd0, 1'b1);
    access("R13", 32'h0400_0008, 2'd2, 1'b0);
    access("R12", 32'h0400_0010, 2'd1, 1'b1);
    access("R11", 32'h0600_0000, 2'd1, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < NCS; i++) begin
      sh_base[i] = '0; sh_mask[i] = '0; sh_en[i] = 1'b0; sh_w[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_bit();
    t_region_sizes();
    t_low_mb();
    t_window();
    t_priority();
    t_width();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule